// File: doc/BRIEF.md
# ADC Host Register Interface

This block is the bus-facing register set of an 8-bit multi-channel analog-to-digital converter. It sits between a byte-wide processor bus and the converter core. A control register holds a 4-bit multiplexer address and a start-conversion request. The address is decoded into a one-hot channel select. A start request becomes a single-cycle start pulse to the converter. When the converter reports completion, the block latches the 8-bit result and sets an end-of-conversion flag.

A second, read-only register returns the live logic levels of the six shared input pins together with the current multiplexer address. A shared pin reads back as a digital level even while it is also used as an analog input.

Each bus access moves one byte. A byte-lane select picks the upper or lower half of a 16-bit register. A 16-bit control write is an upper-byte write followed by a lower-byte write, with no other access between them. The converter core is outside this block; it is modelled as a done strobe with a result bus.

Top module: `adcHostRegs`

## Requirements
- R1: A control write to the lower byte on its own loads bits 3..0 of the data byte into the multiplexer address. Bits 7..4 are ignored, no start pulse is issued, and the end-of-conversion flag is unchanged.
- R2: A 16-bit control write is an upper-byte write followed, as the very next access, by a lower-byte write. Its effects take place only on the lower byte. An upper-byte write that is not followed in this way has no effect.
- R3: When a 16-bit control write has bit 0 of its upper byte set, `convStart` is high for exactly one cycle, in the cycle after the lower-byte access. Bits 7..1 of the upper byte are ignored.
- R4: `chanSel` bit n is set only when the address equals n. Codes 0 to 5 select bits 0 to 5 (bit 1 is the positive reference). Codes 10 to 15 select bits 10 to 15.
- R5: Codes 6 to 9 drive `chanSel` to all zeros. A start request with such a code still pulses `convStart`, and the following completion still sets the flag.
- R6: A start request is ignored while a conversion is in progress. A conversion is in progress from the start pulse until `convDone`.
- R7: `convDone` during a conversion latches `convResult` and sets the end-of-conversion flag. `convDone` with no conversion in progress is ignored.
- R8: The end-of-conversion flag is cleared only by a 16-bit control write. Single-byte writes, reads and writes to the digital register leave it set.
- R9: Reading register select 0, upper byte, returns the flag in bit 7 and zeros in bits 6..0. Reading the lower byte returns the latched result.
- R10: Reading register select 1, upper byte, returns `pinLevel[5:0]` in bits 7..2 and address bits 3..2 in bits 1..0. Reading the lower byte returns address bits 1..0 in bits 7..6 and zeros in bits 5..0. Writes to register select 1 are ignored.
- R11: After reset the address is 0 (`chanSel` = 1), the flag and result are 0, and `convStart` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | One-cycle bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busHiByte | input | 1 | 1 = upper byte, 0 = lower byte |
| busRegSel | input | 1 | 0 = control/conversion data, 1 = digital data |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Read data byte, combinational from the current selects |
| pinLevel | input | 6 | Live levels of the shared pins, bit 5 first in read order |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convDone | input | 1 | Converter completion strobe |
| convResult | input | 8 | Converter result, valid with `convDone` |
| chanSel | output | 16 | One-hot multiplexer channel select, indexed by address code |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 8-bit result and codes 6 to 9 reserved. With these values every one of the sixteen codes can be swept, and both edges of the reserved hole can be checked against the one-hot output. The bench also interleaves lone bytes, reads and broken pairs with 16-bit writes. This exposes the byte pairing, the flag-clear rule and the busy rule, each through values that can be read back.

// File: rtl/adcHostPkg.sv
package adcHostPkg;
  typedef struct packed {
    logic loadAddr;
    logic clearEoc;
    logic latchResult;
  } ctrlStrobe_t;
endpackage

// File: rtl/adcHostCtrl.sv
module adcHostCtrl
  import adcHostPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic        busHiByte,
  input  logic        busRegSel,
  input  logic        startBit,
  input  logic        convDone,
  output ctrlStrobe_t strobe,
  output logic        convStart,
  output logic        busy
);
  logic ctrlWrite, hiWrite, loWrite, pairDone, startGo;
  logic pendValid, pendStart;

  assign ctrlWrite = busSel & busWr & ~busRegSel;
  assign hiWrite   = ctrlWrite & busHiByte;
  assign loWrite   = ctrlWrite & ~busHiByte;
  // The second byte of a pair completes the 16-bit write.
  assign pairDone  = loWrite & pendValid;
  assign startGo   = pairDone & pendStart & ~busy;

  always_comb begin
    strobe.loadAddr    = loWrite;
    strobe.clearEoc    = pairDone;
    strobe.latchResult = convDone & busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendStart <= 1'b0;
      convStart <= 1'b0;
      busy      <= 1'b0;
    end else begin
      // Any access either opens a pair or breaks the pending one.
      if (busSel) begin
        pendValid <= hiWrite;
        pendStart <= hiWrite & startBit;
      end
      convStart <= startGo;
      if (startGo)       busy <= 1'b1;
      else if (convDone) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/adcHostData.sv
module adcHostData
  import adcHostPkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RESULT_W = 8,
  parameter int PIN_W    = 6,
  parameter int RES_LO   = 6,
  parameter int RES_HI   = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [7:0]           busWdata,
  input  logic                 busHiByte,
  input  logic                 busRegSel,
  input  logic [PIN_W-1:0]     pinLevel,
  input  logic [RESULT_W-1:0]  convResult,
  output logic [7:0]           busRdata,
  output logic [SEL_W-1:0]     chanSel,
  output logic                 eocFlag
);
  localparam int SEL_W = 1 << ADDR_W;

  logic [ADDR_W-1:0]   addrReg;
  logic [RESULT_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      resultReg <= '0;
      eocFlag   <= 1'b0;
    end else begin
      if (strobe.loadAddr)    addrReg   <= busWdata[ADDR_W-1:0];
      if (strobe.latchResult) resultReg <= convResult;
      if (strobe.latchResult)   eocFlag <= 1'b1;
      else if (strobe.clearEoc) eocFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < SEL_W; g++) begin : gDecode
    localparam bit Used = !((g >= RES_LO) && (g <= RES_HI));
    if (Used) begin : gLive
      assign chanSel[g] = (addrReg == ADDR_W'(g));
    end else begin : gHole
      assign chanSel[g] = 1'b0;
    end
  end

  always_comb begin
    unique case ({busRegSel, busHiByte})
      2'b01:   busRdata = {eocFlag, 7'b0};
      2'b00:   busRdata = 8'(resultReg);
      2'b11:   busRdata = {pinLevel, addrReg[3:2]};
      default: busRdata = {addrReg[1:0], 6'b0};
    endcase
  end
endmodule

// File: rtl/adcHostRegs.sv
module adcHostRegs
  import adcHostPkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RESULT_W = 8,
  parameter int PIN_W    = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic                  busHiByte,
  input  logic                  busRegSel,
  input  logic [7:0]            busWdata,
  output logic [7:0]            busRdata,
  input  logic [PIN_W-1:0]      pinLevel,
  output logic                  convStart,
  input  logic                  convDone,
  input  logic [RESULT_W-1:0]   convResult,
  output logic [(1<<ADDR_W)-1:0] chanSel
);
  ctrlStrobe_t strobe;
  logic busy;
  logic eocFlag;

  adcHostCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busHiByte(busHiByte), .busRegSel(busRegSel), .startBit(busWdata[0]),
    .convDone(convDone), .strobe(strobe), .convStart(convStart), .busy(busy)
  );

  adcHostData #(.ADDR_W(ADDR_W), .RESULT_W(RESULT_W), .PIN_W(PIN_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busHiByte(busHiByte), .busRegSel(busRegSel), .pinLevel(pinLevel),
    .convResult(convResult), .busRdata(busRdata), .chanSel(chanSel),
    .eocFlag(eocFlag)
  );
endmodule

// File: rtl/adcHostRegsChk.sv
module adcHostRegsChk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic             busHiByte,
  input logic             busRegSel,
  input logic [7:0]       busWdata,
  input logic             convStart,
  input logic             convDone,
  input logic [SEL_W-1:0] chanSel,
  input logic             busy,
  input logic             eocFlag
);
  logic loCtrlWrite;
  assign loCtrlWrite = busSel && busWr && !busRegSel && !busHiByte;

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_start_after_low_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(loCtrlWrite));

  assert_select_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanSel));

  assert_reserved_hole_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loCtrlWrite && busWdata[3:0] >= 4'd6 && busWdata[3:0] <= 4'd9) |=> (chanSel == '0));

  assert_no_start_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !$past(busy));

  assert_flag_set_by_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocFlag) |-> $past(convDone));

  assert_flag_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocFlag) |-> $past(loCtrlWrite));
endmodule

bind adcHostRegs adcHostRegsChk #(.SEL_W(1 << ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busHiByte(busHiByte), .busRegSel(busRegSel), .busWdata(busWdata),
  .convStart(convStart), .convDone(convDone), .chanSel(chanSel),
  .busy(busy), .eocFlag(eocFlag)
);

// File: tb/adcHostRegs_test.sv
module adcHostRegs_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, busHiByte = 1'b0, busRegSel = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [5:0] pinLevel = 6'b010110;
  logic convStart;
  logic convDone = 1'b0;
  logic [7:0] convResult = '0;
  logic [15:0] chanSel;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  adcHostRegs uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busHiByte(busHiByte), .busRegSel(busRegSel), .busWdata(busWdata),
    .busRdata(busRdata), .pinLevel(pinLevel), .convStart(convStart),
    .convDone(convDone), .convResult(convResult), .chanSel(chanSel)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic hi, input logic regSel, input logic [7:0] data);
    @(negedge clk);
    busSel = 1; busWr = 1; busHiByte = hi; busRegSel = regSel; busWdata = data;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic hi, input logic regSel, output logic [7:0] data);
    @(negedge clk);
    busSel = 1; busWr = 0; busHiByte = hi; busRegSel = regSel;
    #1 data = busRdata;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic finishConv(input logic [7:0] r);
    @(negedge clk);
    convDone = 1; convResult = r;
    @(posedge clk); #1;
    convDone = 0;
  endtask

  // The start pulse is sampled at the negedge that follows the lower-byte write.
  task automatic pairWrite(input logic [7:0] hiB, input logic [7:0] loB,
                           input logic expStart, input string tag);
    busWrite(1, 0, hiB);
    busWrite(0, 0, loB);
    @(negedge clk);
    check({tag, " start pulse"}, 16'(convStart), 16'(expStart));
    @(negedge clk);
    check({tag, " pulse one cycle"}, 16'(convStart), 16'h0);
  endtask

  task automatic testReset;
    logic [7:0] d;
    @(negedge clk);
    check("R11 chanSel", chanSel, 16'h0001);
    check("R11 convStart", 16'(convStart), 16'h0);
    busRead(1, 0, d); check("R11 flag", 16'(d), 16'h00);
    busRead(0, 0, d); check("R11 result", 16'(d), 16'h00);
  endtask

  task automatic testLoneLow;
    logic [7:0] d;
    busWrite(0, 0, 8'hF3);
    @(negedge clk);
    check("R1 addr upper nibble ignored", chanSel, 16'h0008);
    check("R1 no start", 16'(convStart), 16'h0);
    busRead(0, 1, d); check("R10 digital lo", 16'(d), 16'hC0);
    busRead(1, 1, d); check("R10 digital hi", 16'(d), 16'({pinLevel, 2'b00}));
  endtask

  task automatic testDecode;
    for (int c = 0; c < 16; c++) begin
      busWrite(0, 0, 8'(c));
      @(negedge clk);
      if (c >= 6 && c <= 9) check("R5 reserved code", chanSel, 16'h0);
      else check("R4 decode", chanSel, 16'(1) << c);
    end
  endtask

  task automatic testBrokenPair;
    busWrite(1, 0, 8'h01);
    @(negedge clk); check("R2 lone upper no start", 16'(convStart), 16'h0);
    check("R2 lone upper keeps addr", chanSel, 16'h8000);
    busWrite(1, 0, 8'h01);
    busWrite(1, 1, 8'h00);
    busWrite(0, 0, 8'h02);
    @(negedge clk); check("R2 broken pair no start", 16'(convStart), 16'h0);
    check("R2 lower byte still loads", chanSel, 16'h0004);
  endtask

  task automatic testStartAndBusy;
    logic [7:0] d;
    pairWrite(8'hFF, 8'h0B, 1, "R3");
    check("R3 address loaded", chanSel, 16'h0800);
    pairWrite(8'h01, 8'h0C, 0, "R6 busy");
    finishConv(8'hA5);
    busRead(1, 0, d); check("R7 flag set", 16'(d), 16'h80);
    busRead(0, 0, d); check("R9 result", 16'(d), 16'hA5);
    finishConv(8'h3C);
    busRead(0, 0, d); check("R7 idle done ignored", 16'(d), 16'hA5);
  endtask

  task automatic testFlagRules;
    logic [7:0] d;
    busWrite(0, 0, 8'h02);
    busWrite(1, 0, 8'h00);
    busRead(0, 1, d);
    busWrite(1, 1, 8'hFF);
    busWrite(0, 1, 8'h0E);
    @(negedge clk); check("R10 digital write ignored", chanSel, 16'h0004);
    busRead(1, 0, d); check("R8 flag survives", 16'(d), 16'h80);
    pairWrite(8'h00, 8'h03, 0, "R8 clear");
    busRead(1, 0, d); check("R8 flag cleared", 16'(d), 16'h00);
  endtask

  task automatic testReservedStart;
    logic [7:0] d;
    pairWrite(8'h01, 8'h07, 1, "R5");
    check("R5 no channel", chanSel, 16'h0);
    finishConv(8'h11);
    busRead(1, 0, d); check("R5 flag on dummy", 16'(d), 16'h80);
    busRead(0, 0, d); check("R5 result", 16'(d), 16'h11);
    @(negedge clk) pinLevel = 6'b101101;
    busRead(1, 1, d); check("R10 live pins", 16'(d), 16'({6'b101101, 2'b01}));
    busRead(0, 1, d); check("R10 addr low bits", 16'(d), 16'hC0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset;
    testLoneLow;
    testDecode;
    testBrokenPair;
    testStartAndBusy;
    testFlagRules;
    testReservedStart;
    report;
  end

  initial begin
    #(ClkPeriod * 20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report;
  end
endmodule